// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is a single timer channel built around a free-running counter and two general registers, called slot A and slot B. A control register holds one 3-bit mode code per slot. The code decides whether the slot works as an output-compare register or as an input-capture register. An output-compare slot watches for the counter reaching its value and then drives its pin low, high or to the opposite level. An input-capture slot latches the counter when its pin shows a selected edge. Each slot raises a sticky flag when it matches or captures.

Software reaches the block through a flat register port. The port writes on `bus_we` at the clock edge, and `bus_rdata` always returns the register chosen by `bus_addr`, with no read strobe. Each pin has an output level, an output enable and a raw input. The raw input goes through a two-flop synchronizer before edge detection. The parameter `FORCE_HIGH_CH` sets the channel variant. On that variant, the toggle code drives the pin high instead of toggling it.

Each slot runs a four-state pin machine:
- PS_IDLE: pin disabled, code 000.
- PS_LOW: driving 0.
- PS_HIGH: driving 1.
- PS_SENSE: capture role, pin not driven.

The machine moves as follows:
- Every state goes to PS_IDLE when the code is 000.
- Every state goes to PS_SENSE when the code is a capture code.
- PS_IDLE and PS_SENSE go to PS_LOW when a compare code is chosen.
- PS_LOW and PS_HIGH move to each other on a compare match, as the code dictates.
- Otherwise a compare state holds its level.

Top module: `tmr_capcmp_chan`

## Requirements
- R1: After reset the control register reads 0x88 at address 0, both general registers (addresses 1 and 2) read 0xFFFF, the counter (address 4) reads 0, and both flags and both output enables are 0.
- R2: Bits 7 and 3 of the control register always read 1, and writes to them are ignored. Bits 2:0 are the slot A code and bits 6:4 are the slot B code.
- R3: The counter increments by one on every clock with `cnt_en` high and wraps from 0xFFFF to 0x0000. A write to address 4 loads the counter and takes priority over the increment.
- R4: A compare match happens in a cycle where `cnt_en` is high, the slot is not in a capture code, and the counter equals the slot's register. The match sets the slot flag (flags read at address 3: bit 0 is A, bit 1 is B), and the pin level changes at the following clock edge.
- R5: Code 001 drives the pin 0 on a match and code 010 drives it 1. The output enable is high for codes 001 to 011. The level holds between matches and across changes among codes 001 to 011. A slot entering a compare code from code 000 or a capture code starts at level 0.
- R6: Code 011 inverts the pin on each match when FORCE_HIGH_CH is 0. When FORCE_HIGH_CH is 1, code 011 drives the pin 1 on a match instead.
- R7: Code 000 keeps the output enable low, and a compare match still sets the flag.
- R8: Code 100 captures on a rising synchronized edge and code 101 captures on a falling one; the other edge is ignored. A pin change made just after clock edge n is captured at edge n+3. The value captured is the counter value present after edge n+2, and the flag sets at the same edge.
- R9: Codes 110 and 111 both capture on either edge (bit 0 of the code is ignored).
- R10: In any capture code the output enable is low.
- R11: A software write to a slot's register in the same cycle as a capture into it is discarded in favour of the captured counter value. A write with no capture loads the register.
- R12: Writing 1 to a flag bit at address 3 clears it, and writing 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Counter advance enable |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address (0 ctrl, 1 A, 2 B, 3 flags, 4 counter) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register |
| pin_a_in | input | 1 | Raw input of pin A |
| pin_a_out | output | 1 | Output level of pin A |
| pin_a_oe | output | 1 | Output enable of pin A |
| pin_b_in | input | 1 | Raw input of pin B |
| pin_b_out | output | 1 | Output level of pin B |
| pin_b_oe | output | 1 | Output enable of pin B |
| flag_a | output | 1 | Sticky match/capture flag of slot A |
| flag_b | output | 1 | Sticky match/capture flag of slot B |

## Verification
The hardest case to reach is a capture landing in exactly the cycle in which software writes the same register. The pin change only becomes visible three edges after it is driven. The stimulus therefore raises the pin and enables counting together, waits two edges, and then issues the register write so that it falls on the capture edge.

Counter wrap and the forced-high variant are also reached deliberately. Wrap comes from loading the counter near its top. The variant comes from a second instance built with FORCE_HIGH_CH set and fed the same stimulus, so the toggle and forced-high outcomes can be told apart on the same matches.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_GRA  = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_GRB  = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_FLAG = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_CNT  = 3'd4;

    // Pin machine states of one slot
    typedef enum logic [1:0] {
        PS_IDLE,
        PS_LOW,
        PS_HIGH,
        PS_SENSE
    } pin_state_e;

    // Decoded action of a 3-bit mode code
    typedef enum logic [2:0] {
        ACT_OFF,
        ACT_CLR,
        ACT_SET,
        ACT_TGL,
        ACT_RISE,
        ACT_FALL,
        ACT_BOTH
    } slot_act_e;

    function automatic slot_act_e decode_act(input logic [2:0] code);
        slot_act_e a;
        unique casez (code)
            3'b000:  a = ACT_OFF;
            3'b001:  a = ACT_CLR;
            3'b010:  a = ACT_SET;
            3'b011:  a = ACT_TGL;
            3'b100:  a = ACT_RISE;
            3'b101:  a = ACT_FALL;
            3'b11?:  a = ACT_BOTH;
            default: a = ACT_OFF;
        endcase
        return a;
    endfunction

    function automatic logic act_is_capture(input slot_act_e a);
        return (a == ACT_RISE) || (a == ACT_FALL) || (a == ACT_BOTH);
    endfunction

endpackage

// File: rtl/tmr_free_counter.sv
module tmr_free_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt_en) begin
            cnt <= cnt + ONE;   // wraps naturally at the top
        end
    end

endmodule

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw,
    output logic edge_rise,
    output logic edge_fall
);

    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], pin_raw};
            prev  <= chain[STAGES-1];
        end
    end

    assign edge_rise =  chain[STAGES-1] & ~prev;
    assign edge_fall = ~chain[STAGES-1] &  prev;

endmodule

// File: rtl/tmr_gr_slot.sv
module tmr_gr_slot
    import tmr_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter bit FORCE_HIGH = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mode_code,
    input  logic [CNT_W-1:0] cnt,
    input  logic             cnt_en,
    input  logic             wr_hit,
    input  logic [CNT_W-1:0] wdata,
    input  logic             flag_clr,
    input  logic             edge_rise,
    input  logic             edge_fall,
    output logic [CNT_W-1:0] gr,
    output logic             pin_out,
    output logic             pin_oe,
    output logic             flag,
    output logic             cap_pulse
);

    slot_act_e  act;
    pin_state_e state_q;
    pin_state_e state_d;
    logic       match;
    logic       level_base;
    logic       level_next;

    assign act = decode_act(mode_code);

    always_comb begin
        cap_pulse = ((act == ACT_RISE) && edge_rise)
                 || ((act == ACT_FALL) && edge_fall)
                 || ((act == ACT_BOTH) && (edge_rise || edge_fall));
    end

    assign match = !act_is_capture(act) && cnt_en && (cnt == gr);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        level_base = (state_q == PS_HIGH);
        level_next = level_base;
        state_d    = state_q;
        unique case (act)
            ACT_OFF: begin
                state_d = PS_IDLE;
            end
            ACT_RISE, ACT_FALL, ACT_BOTH: begin
                state_d = PS_SENSE;
            end
            ACT_CLR: begin
                if (match) level_next = 1'b0;
                state_d = level_next ? PS_HIGH : PS_LOW;
            end
            ACT_SET: begin
                if (match) level_next = 1'b1;
                state_d = level_next ? PS_HIGH : PS_LOW;
            end
            ACT_TGL: begin
                if (match) level_next = FORCE_HIGH ? 1'b1 : ~level_base;
                state_d = level_next ? PS_HIGH : PS_LOW;
            end
            default: begin
                state_d = PS_IDLE;
            end
        endcase
    end

    // Outputs from state
    always_comb begin
        pin_oe  = (state_q == PS_LOW) || (state_q == PS_HIGH);
        pin_out = (state_q == PS_HIGH);
    end

    // General register: capture beats software write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gr <= '1;
        end else if (cap_pulse) begin
            gr <= cnt;
        end else if (wr_hit) begin
            gr <= wdata;
        end
    end

    // Sticky flag: setting beats clearing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (cap_pulse || match) begin
            flag <= 1'b1;
        end else if (flag_clr) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/tmr_capcmp_chan.sv
module tmr_capcmp_chan
    import tmr_pkg::*;
#(
    parameter int CNT_W         = 16,
    parameter int SYNC_STAGES   = 2,
    parameter bit FORCE_HIGH_CH = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              pin_a_in,
    output logic              pin_a_out,
    output logic              pin_a_oe,
    input  logic              pin_b_in,
    output logic              pin_b_out,
    output logic              pin_b_oe,
    output logic              flag_a,
    output logic              flag_b
);

    localparam int N_SLOT  = 2;
    localparam int FIELD_W = 4;   // 3-bit code plus one fixed bit per slot

    logic [N_SLOT-1:0][2:0]       mode_q;
    logic [N_SLOT-1:0][CNT_W-1:0] gr_val;
    logic [N_SLOT-1:0]            pin_raw;
    logic [N_SLOT-1:0]            pin_o;
    logic [N_SLOT-1:0]            pin_e;
    logic [N_SLOT-1:0]            flg;
    logic [N_SLOT-1:0]            cap_hit;
    logic [N_SLOT-1:0]            rise;
    logic [N_SLOT-1:0]            fall;
    logic [N_SLOT-1:0]            wr_gr;
    logic [CNT_W-1:0]             cnt_q;
    logic [2:0]                   mode_a;
    logic [2:0]                   mode_b;
    logic [CNT_W-1:0]             gr_a;
    logic [CNT_W-1:0]             gr_b;
    logic                         cap_a;
    logic                         cap_b;
    logic                         wr_ctrl;
    logic                         wr_flag;
    logic                         wr_cnt;

    assign wr_ctrl  = bus_we && (bus_addr == ADDR_CTRL);
    assign wr_flag  = bus_we && (bus_addr == ADDR_FLAG);
    assign wr_cnt   = bus_we && (bus_addr == ADDR_CNT);
    assign wr_gr[0] = bus_we && (bus_addr == ADDR_GRA);
    assign wr_gr[1] = bus_we && (bus_addr == ADDR_GRB);

    assign pin_raw = {pin_b_in, pin_a_in};

    tmr_free_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_en   (cnt_en),
        .load     (wr_cnt),
        .load_val (bus_wdata),
        .cnt      (cnt_q)
    );

    for (genvar i = 0; i < N_SLOT; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mode_q[i] <= 3'b000;
            end else if (wr_ctrl) begin
                mode_q[i] <= bus_wdata[i*FIELD_W +: 3];
            end
        end

        tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_raw   (pin_raw[i]),
            .edge_rise (rise[i]),
            .edge_fall (fall[i])
        );

        tmr_gr_slot #(.CNT_W(CNT_W), .FORCE_HIGH(FORCE_HIGH_CH)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .mode_code (mode_q[i]),
            .cnt       (cnt_q),
            .cnt_en    (cnt_en),
            .wr_hit    (wr_gr[i]),
            .wdata     (bus_wdata),
            .flag_clr  (wr_flag && bus_wdata[i]),
            .edge_rise (rise[i]),
            .edge_fall (fall[i]),
            .gr        (gr_val[i]),
            .pin_out   (pin_o[i]),
            .pin_oe    (pin_e[i]),
            .flag      (flg[i]),
            .cap_pulse (cap_hit[i])
        );
    end

    assign mode_a = mode_q[0];
    assign mode_b = mode_q[1];
    assign gr_a   = gr_val[0];
    assign gr_b   = gr_val[1];
    assign cap_a  = cap_hit[0];
    assign cap_b  = cap_hit[1];

    assign pin_a_out = pin_o[0];
    assign pin_a_oe  = pin_e[0];
    assign pin_b_out = pin_o[1];
    assign pin_b_oe  = pin_e[1];
    assign flag_a    = flg[0];
    assign flag_b    = flg[1];

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_CTRL: bus_rdata[7:0] = {1'b1, mode_b, 1'b1, mode_a};
            ADDR_GRA:  bus_rdata = gr_a;
            ADDR_GRB:  bus_rdata = gr_b;
            ADDR_FLAG: bus_rdata[N_SLOT-1:0] = flg;
            ADDR_CNT:  bus_rdata = cnt_q;
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/tmr_capcmp_chan_chk.sv
module tmr_capcmp_chan_chk
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cnt_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [CNT_W-1:0]  bus_rdata,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [2:0]        mode_a,
    input logic [2:0]        mode_b,
    input logic [CNT_W-1:0]  gr_a,
    input logic [CNT_W-1:0]  gr_b,
    input logic              cap_a,
    input logic              cap_b,
    input logic              pin_a_oe,
    input logic              pin_b_oe,
    input logic              flag_a
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic cnt_load;
    assign cnt_load = bus_we && (bus_addr == ADDR_CNT);

    assert_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_CTRL) |-> (bus_rdata[7] && bus_rdata[3]));

    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !cnt_load && (cnt_q != '1)) |=> (cnt_q == $past(cnt_q) + ONE));

    assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !cnt_load && (cnt_q == '1)) |=> (cnt_q == '0));

    assert_match_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !mode_a[2] && (cnt_q == gr_a)) |=> flag_a);

    assert_idle_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_a == 3'b000) && ($past(mode_a) == 3'b000)) |-> !pin_a_oe);

    assert_capture_oe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_b[2] && $past(mode_b[2])) |-> !pin_b_oe);

    assert_capture_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cap_a |=> (gr_a == $past(cnt_q)));

    assert_capture_priority_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_b && bus_we && (bus_addr == ADDR_GRB)) |=> (gr_b == $past(cnt_q)));

endmodule

bind tmr_capcmp_chan tmr_capcmp_chan_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_en    (cnt_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .cnt_q     (cnt_q),
    .mode_a    (mode_a),
    .mode_b    (mode_b),
    .gr_a      (gr_a),
    .gr_b      (gr_b),
    .cap_a     (cap_a),
    .cap_b     (cap_b),
    .pin_a_oe  (pin_a_oe),
    .pin_b_oe  (pin_b_oe),
    .flag_a    (flag_a)
);

// File: tb/tmr_capcmp_chan_test.sv
`timescale 1ns/1ps
module tmr_capcmp_chan_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cnt_en;
    logic        bus_we;
    logic [2:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic [15:0] sp_rdata;
    logic        pin_a_in, pin_b_in;
    logic        pin_a_out, pin_a_oe, pin_b_out, pin_b_oe, flag_a, flag_b;
    logic        sp_a_out, sp_a_oe, sp_b_out, sp_b_oe, sp_flag_a, sp_flag_b;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        string       req;
        string       what;
        int          sel;
        logic [15:0] exp;
    } exp_item_t;

    exp_item_t exp_q[$];

    always #2.5 clk = ~clk;   // 200 MHz

    tmr_capcmp_chan uut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_a_in(pin_a_in), .pin_a_out(pin_a_out), .pin_a_oe(pin_a_oe),
        .pin_b_in(pin_b_in), .pin_b_out(pin_b_out), .pin_b_oe(pin_b_oe),
        .flag_a(flag_a), .flag_b(flag_b)
    );

    tmr_capcmp_chan #(.FORCE_HIGH_CH(1'b1)) uut_sp (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(sp_rdata),
        .pin_a_in(pin_a_in), .pin_a_out(sp_a_out), .pin_a_oe(sp_a_oe),
        .pin_b_in(pin_b_in), .pin_b_out(sp_b_out), .pin_b_oe(sp_b_oe),
        .flag_a(sp_flag_a), .flag_b(sp_flag_b)
    );

    function automatic logic [15:0] observe(input int sel);
        case (sel)
            0: return bus_rdata;
            1: return {15'd0, pin_a_out};
            2: return {15'd0, pin_a_oe};
            3: return {15'd0, pin_b_out};
            4: return {15'd0, pin_b_oe};
            5: return {15'd0, flag_a};
            6: return {15'd0, flag_b};
            7: return {15'd0, sp_a_out};
            default: return 16'hDEAD;
        endcase
    endfunction

    // Monitor: pops expectations and compares away from the active edge
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            exp_item_t it;
            logic [15:0] act;
            it  = exp_q.pop_front();
            act = observe(it.sel);
            n_tests++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s %s: actual 0x%04h expected 0x%04h", it.req, it.what, act, it.exp);
            end
        end
    end

    // Driver side
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_sig(input string req, input string what, input int sel, input logic [15:0] exp);
        exp_item_t it;
        it.req = req; it.what = what; it.sel = sel; it.exp = exp;
        exp_q.push_back(it);
        wait (exp_q.size() == 0);
    endtask

    task automatic expect_reg(input string req, input string what, input logic [2:0] a, input logic [15:0] exp);
        bus_addr = a;
        expect_sig(req, what, 0, exp);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        tick(1);
        bus_we = 1'b0;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cnt_en = 1'b0; bus_we = 1'b0; bus_addr = 3'd0;
        bus_wdata = 16'd0; pin_a_in = 1'b0; pin_b_in = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        expect_reg("R1", "ctrl reset", 3'd0, 16'h0088);
        expect_reg("R1", "GRA reset", 3'd1, 16'hFFFF);
        expect_reg("R1", "GRB reset", 3'd2, 16'hFFFF);
        expect_reg("R1", "counter reset", 3'd4, 16'h0000);
        expect_sig("R1", "oe A reset", 2, 16'd0);
        expect_sig("R1", "oe B reset", 4, 16'd0);
        expect_sig("R1", "flag A reset", 5, 16'd0);
        expect_sig("R1", "flag B reset", 6, 16'd0);

        // R2 reserved bits
        wr(3'd0, 16'h0011);
        expect_reg("R2", "ctrl 0x11", 3'd0, 16'h0099);
        wr(3'd0, 16'h0000);
        expect_reg("R2", "ctrl zero write", 3'd0, 16'h0088);

        // R4/R5 set-high on match
        wr(3'd1, 16'd10);
        wr(3'd0, 16'h0002);
        tick(1);
        expect_sig("R5", "entry oe", 2, 16'd1);
        expect_sig("R5", "entry level low", 1, 16'd0);
        wr(3'd4, 16'd5);
        cnt_en = 1'b1;
        tick(5);
        expect_sig("R4", "no early change", 1, 16'd0);
        tick(1);
        cnt_en = 1'b0;
        expect_sig("R4", "high after match", 1, 16'd1);
        expect_sig("R4", "flag A on match", 5, 16'd1);
        expect_reg("R3", "counter after 6", 3'd4, 16'd11);

        // R12 clear
        wr(3'd3, 16'h0001);
        expect_sig("R12", "flag A cleared", 5, 16'd0);

        // R5 clear-low, level held across code change
        wr(3'd0, 16'h0001);
        tick(1);
        expect_sig("R5", "level held", 1, 16'd1);
        wr(3'd4, 16'd8);
        cnt_en = 1'b1;
        tick(2);
        expect_sig("R5", "before clear", 1, 16'd1);
        tick(1);
        cnt_en = 1'b0;
        expect_sig("R5", "low after match", 1, 16'd0);

        // R6 toggle vs forced high
        wr(3'd0, 16'h0003);
        tick(1);
        wr(3'd4, 16'd8);
        cnt_en = 1'b1;
        tick(3);
        cnt_en = 1'b0;
        expect_sig("R6", "toggle to high", 1, 16'd1);
        expect_sig("R6", "forced high variant", 7, 16'd1);
        wr(3'd4, 16'd9);
        cnt_en = 1'b1;
        tick(2);
        cnt_en = 1'b0;
        expect_sig("R6", "toggle back low", 1, 16'd0);
        expect_sig("R6", "variant stays high", 7, 16'd1);

        // R7 disabled pin, flag still sets
        wr(3'd0, 16'h0000);
        tick(1);
        wr(3'd3, 16'h0001);
        expect_sig("R7", "oe off", 2, 16'd0);
        wr(3'd4, 16'd8);
        cnt_en = 1'b1;
        tick(3);
        cnt_en = 1'b0;
        expect_sig("R7", "flag on match", 5, 16'd1);
        expect_sig("R7", "oe still off", 2, 16'd0);

        // R8 rising capture
        wr(3'd3, 16'h0003);
        wr(3'd0, 16'h0040);
        tick(1);
        expect_sig("R10", "capture oe off", 4, 16'd0);
        wr(3'd4, 16'd100);
        cnt_en = 1'b1; pin_b_in = 1'b1;
        tick(3);
        cnt_en = 1'b0;
        expect_sig("R8", "rise flag", 6, 16'd1);
        expect_reg("R8", "rise value", 3'd2, 16'd102);
        wr(3'd3, 16'h0002);
        pin_b_in = 1'b0;
        tick(4);
        expect_sig("R8", "fall ignored flag", 6, 16'd0);
        expect_reg("R8", "fall ignored value", 3'd2, 16'd102);

        // R8 falling capture
        wr(3'd0, 16'h0050);
        pin_b_in = 1'b1;
        tick(4);
        expect_sig("R8", "rise ignored in fall mode", 6, 16'd0);
        wr(3'd4, 16'd200);
        cnt_en = 1'b1; pin_b_in = 1'b0;
        tick(3);
        cnt_en = 1'b0;
        expect_sig("R8", "fall flag", 6, 16'd1);
        expect_reg("R8", "fall value", 3'd2, 16'd202);

        // R9 both edges, low bit ignored
        wr(3'd0, 16'h0070);
        wr(3'd3, 16'h0002);
        wr(3'd4, 16'd300);
        cnt_en = 1'b1; pin_b_in = 1'b1;
        tick(3);
        cnt_en = 1'b0;
        expect_sig("R9", "111 rise flag", 6, 16'd1);
        expect_reg("R9", "111 rise value", 3'd2, 16'd302);
        wr(3'd0, 16'h0060);
        wr(3'd3, 16'h0002);
        wr(3'd4, 16'd400);
        cnt_en = 1'b1; pin_b_in = 1'b0;
        tick(3);
        cnt_en = 1'b0;
        expect_sig("R9", "110 fall flag", 6, 16'd1);
        expect_reg("R9", "110 fall value", 3'd2, 16'd402);
        expect_sig("R10", "both-edge oe off", 4, 16'd0);

        // R11 capture beats same-cycle write
        wr(3'd0, 16'h0040);
        wr(3'd3, 16'h0002);
        wr(3'd4, 16'd500);
        cnt_en = 1'b1; pin_b_in = 1'b1;
        tick(2);
        wr(3'd2, 16'h1234);
        cnt_en = 1'b0;
        expect_reg("R11", "capture wins", 3'd2, 16'd502);
        wr(3'd2, 16'h1111);
        expect_reg("R11", "plain write", 3'd2, 16'h1111);

        // R12 write-0 no effect, write-1 clears
        wr(3'd3, 16'h0000);
        expect_sig("R12", "write 0 keeps flag", 6, 16'd1);
        wr(3'd3, 16'h0002);
        expect_sig("R12", "write 1 clears flag", 6, 16'd0);

        // R3 wrap and load
        wr(3'd4, 16'hFFFE);
        cnt_en = 1'b1;
        tick(2);
        cnt_en = 1'b0;
        expect_reg("R3", "wrap to zero", 3'd4, 16'h0000);
        wr(3'd4, 16'd7);
        expect_reg("R3", "counter load", 3'd4, 16'd7);

        tick(2);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule